// File: doc/BRIEF.md
# Filtered Quadrature and Pulse Decoder

This block is the per-channel front end of an incremental-encoder counter. It receives the raw A, B and index lines and turns them into a single-cycle count strobe with a direction bit, plus a single-cycle index strobe. A counter core downstream uses these strobes. The counter arithmetic and any register access are outside the block. All inputs are taken to be synchronous to `clk`. Synchronisation of external pins happens upstream.

A, B and index first pass through a glitch filter. The filter is clocked by a sample tick that a loadable 8-bit prescaler derives from `clk`. The filtered A and B are then decoded in one of four modes, selected on `mode`:

| `mode` | Decoding |
|---|---|
| 0 | pulse/direction |
| 1 | quadrature x1 |
| 2 | quadrature x2 |
| 3 | quadrature x4 |

A sticky `noise_err` flag records two kinds of input trouble: samples rejected by the filter, and quadrature steps in which A and B both moved together. The index strobe is qualified by a polarity. It can optionally be tied to the A/B state.

All outputs are plain strobes and levels. There is no back-pressure: each strobe is valid for exactly one `clk` cycle and must be taken in that cycle.

Top module: `quad_front`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `cnt_en`, `cnt_up`, `idx_hit` and `noise_err` are 0. The prescaler value is reset to 0.
- R2: With `mode`=0, each filtered rising edge of A gives one `cnt_en` strobe, and `cnt_up` takes the filtered B level (1 means up). A falling edges and B changes give no strobe.
- R3: With `mode`=1, a forward cycle gives one up count, on the A rising edge. A backward cycle gives one down count, on the A falling edge. Forward means the {A,B} states step 00, 10, 11, 01, 00.
- R4: With `mode`=2, every single-input step that moves A counts, in the step's direction. A full cycle therefore gives two counts.
- R5: With `mode`=3, every single-input step of A or B counts, in the step's direction. A full cycle therefore gives four counts.
- R6: While `ab_enable` is 0, no `cnt_en` strobe is produced in any mode.
- R7: A filtered input takes a new value only when two consecutive sample ticks see that same value. With prescaler 0, `cnt_en` rises 3 `clk` edges after the A edge that causes it. A one-cycle pulse is not counted.
- R8: The sample tick runs at `clk`/(P+1), where P is the prescaler. `psc_load` loads P from `psc_value`. With P=3, a 3-cycle pulse on A is not counted, but a 12-cycle pulse is.
- R9: `noise_err` is set when a sample disagrees with a still-pending earlier sample on A or B. It stays set until `noise_clear` is pulsed.
- R10: In a quadrature mode with `ab_enable` high, a step in which A and B change together gives no count and sets `noise_err`.
- R11: `idx_hit` strobes once on each rising edge of the polarity-adjusted index: the index itself when `idx_pol`=1, and its inverse when `idx_pol`=0.
- R12: With `idx_sync`=1 in a quadrature mode, the index is honoured only while filtered A and B both equal `idx_pol`. In pulse/direction mode, `idx_sync` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_a | input | 1 | raw A (count pulse in mode 0) |
| in_b | input | 1 | raw B (direction in mode 0) |
| in_idx | input | 1 | raw index |
| mode | input | 2 | 0 pulse/dir, 1 x1, 2 x2, 3 x4 |
| ab_enable | input | 1 | allow counting from A/B |
| idx_pol | input | 1 | 1 active-high index, 0 active-low |
| idx_sync | input | 1 | gate index with A/B state |
| psc_load | input | 1 | load prescaler from psc_value |
| psc_value | input | PSC_W | new prescaler value |
| noise_clear | input | 1 | clear the noise flag |
| cnt_en | output | 1 | one-cycle count strobe |
| cnt_up | output | 1 | direction of the last count, 1 up |
| idx_hit | output | 1 | one-cycle index strobe |
| noise_err | output | 1 | sticky input-noise flag |

## Verification
The hardest states to reach from the ports are the two that depend on sample phase: a glitch that the filter rejects, and a pulse that is too short for a slow prescaler. With the prescaler at 0, the bench drives A for exactly one `clk` cycle, so the pending sample is contradicted on the very next tick. With the prescaler at 3, it drives a 3-cycle pulse, which can meet at most one tick whatever the phase. The simultaneous A/B change is forced by changing both inputs on the same edge, so that both settle in the same filter sample. Sync-index gating is reached with counting disabled, so that A/B can be parked in any state without producing count traffic.

// File: rtl/qf_pkg.sv
package qf_pkg;
  typedef enum logic [1:0] {
    MODE_PULSE = 2'd0,
    MODE_X1    = 2'd1,
    MODE_X2    = 2'd2,
    MODE_X4    = 2'd3
  } dec_mode_t;
endpackage

// File: rtl/qf_prescaler.sv
module qf_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PSC_W-1:0] value,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= value;
      cnt_q <= '0;
    end else if (cnt_q == div_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == div_q) && !load;

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0) |=> !tick);
endmodule

// File: rtl/qf_filter.sv
module qf_filter #(
  parameter int         N          = 3,
  parameter logic [N-1:0] NOISE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean,
  output logic         glitch
);
  logic [N-1:0] reject;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic cand_q;
    logic clean_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand_q  <= 1'b0;
        clean_q <= 1'b0;
      end else if (tick) begin
        cand_q <= raw[i];
        if (raw[i] == cand_q) clean_q <= raw[i];
      end
    end
    assign reject[i] = tick && (raw[i] != cand_q) && (cand_q != clean_q);
    assign clean[i]  = clean_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) glitch <= 1'b0;
    else        glitch <= |(reject & NOISE_MASK);
  end

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(clean));
endmodule

// File: rtl/qf_decoder.sv
module qf_decoder
  import qf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  dec_mode_t mode,
  input  logic      ab_en,
  input  logic      idx_pol,
  input  logic      idx_sync,
  input  logic      fa,
  input  logic      fb,
  input  logic      fi,
  input  logic      glitch,
  input  logic      noise_clear,
  output logic      cnt_en,
  output logic      cnt_up,
  output logic      idx_hit,
  output logic      noise_err
);
  logic pa_q, pb_q, pl_q;
  logic a_ch, b_ch, step_up, quad, illegal, hit, dir, want, lvl, sync_ok;

  always_comb begin
    a_ch    = fa ^ pa_q;
    b_ch    = fb ^ pb_q;
    step_up = fa ^ pb_q;
    quad    = (mode != MODE_PULSE);
    illegal = quad && ab_en && a_ch && b_ch;
    dir     = step_up;
    hit     = 1'b0;
    unique case (mode)
      MODE_PULSE: begin hit = fa && !pa_q; dir = fb; end
      MODE_X1:    hit = a_ch && !b_ch && (fa == step_up);
      MODE_X2:    hit = a_ch && !b_ch;
      MODE_X4:    hit = a_ch ^ b_ch;
      default:    hit = 1'b0;
    endcase
    want    = ab_en && hit;
    lvl     = fi ~^ idx_pol;
    sync_ok = !(idx_sync && quad) || ((fa == idx_pol) && (fb == idx_pol));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q <= 1'b0; pb_q <= 1'b0; pl_q <= 1'b0;
      cnt_en <= 1'b0; cnt_up <= 1'b0; idx_hit <= 1'b0; noise_err <= 1'b0;
    end else begin
      pa_q    <= fa;
      pb_q    <= fb;
      pl_q    <= lvl;
      cnt_en  <= want;
      if (want) cnt_up <= dir;
      idx_hit <= lvl && !pl_q && sync_ok;
      if (glitch || illegal) noise_err <= 1'b1;
      else if (noise_clear)  noise_err <= 1'b0;
    end
  end

  // R6
  no_count_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |=> !cnt_en);
  // R10
  illegal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && ab_en && a_ch && b_ch) |=> (!cnt_en && noise_err));
  // R9
  noise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err && !noise_clear) |=> noise_err);
  // R12
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_sync && quad && !(fa == idx_pol && fb == idx_pol)) |=> !idx_hit);
  // R2
  pulse_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE && ab_en && fa && !pa_q) |=> (cnt_en && cnt_up == $past(fb)));
endmodule

// File: rtl/quad_front.sv
module quad_front
  import qf_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_idx,
  input  logic [1:0]       mode,
  input  logic             ab_enable,
  input  logic             idx_pol,
  input  logic             idx_sync,
  input  logic             psc_load,
  input  logic [PSC_W-1:0] psc_value,
  input  logic             noise_clear,
  output logic             cnt_en,
  output logic             cnt_up,
  output logic             idx_hit,
  output logic             noise_err
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] AB_ONLY = 3'b011;

  logic             tick;
  logic [LANES-1:0] clean;
  logic             glitch;
  dec_mode_t        mode_e;

  assign mode_e = dec_mode_t'(mode);

  qf_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .load(psc_load), .value(psc_value), .tick(tick)
  );

  qf_filter #(.N(LANES), .NOISE_MASK(AB_ONLY)) u_flt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .raw({in_idx, in_b, in_a}), .clean(clean), .glitch(glitch)
  );

  qf_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .ab_en(ab_enable),
    .idx_pol(idx_pol), .idx_sync(idx_sync),
    .fa(clean[0]), .fb(clean[1]), .fi(clean[2]),
    .glitch(glitch), .noise_clear(noise_clear),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .idx_hit(idx_hit), .noise_err(noise_err)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!cnt_en && !idx_hit && !noise_err));
endmodule

// File: tb/quad_front_test.sv
module quad_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_a = 0, in_b = 0, in_idx = 0;
  logic [1:0] mode = 2'd0;
  logic ab_enable = 0, idx_pol = 1, idx_sync = 0, psc_load = 0, noise_clear = 0;
  logic [7:0] psc_value = 8'd0;
  logic cnt_en, cnt_up, idx_hit, noise_err;

  int checks = 0, failures = 0;
  int ev_cnt = 0, hit_cnt = 0;
  bit exp_q[$];
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  quad_front uut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .mode(mode), .ab_enable(ab_enable), .idx_pol(idx_pol), .idx_sync(idx_sync),
    .psc_load(psc_load), .psc_value(psc_value), .noise_clear(noise_clear),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .idx_hit(idx_hit), .noise_err(noise_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected directions as strobes appear
  always @(negedge clk) begin
    if (rst_n && cnt_en) begin
      ev_cnt++;
      if (exp_q.size() == 0)
        chk(0, cur_req, "unexpected count strobe", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(cnt_up == e, cur_req, "count direction", cnt_up, e);
      end
    end
    if (rst_n && idx_hit) hit_cnt++;
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input bit a, input bit b);
    @(negedge clk);
    in_a = a; in_b = b;
    settle(6);
  endtask

  task automatic push(input bit up);
    exp_q.push_back(up);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, "expected counts still pending", exp_q.size(), 0);
  endtask

  task automatic clear_noise();
    @(negedge clk); noise_clear = 1;
    @(negedge clk); noise_clear = 0;
  endtask

  task automatic set_idx(input bit v, input int exp_delta, input string req);
    int h0;
    h0 = hit_cnt;
    @(negedge clk); in_idx = v;
    settle(6);
    chk(hit_cnt - h0 == exp_delta, req, "index strobes", hit_cnt - h0, exp_delta);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e0;
    settle(5);
    // R1 reset state
    chk(!cnt_en && !idx_hit && !noise_err && !cnt_up, "R1", "outputs in reset", 1, 0);
    @(negedge clk); rst_n = 1;
    settle(3);
    chk(!cnt_en && !idx_hit && !noise_err, "R1", "outputs after reset", 1, 0);

    // R7 latency and R1 prescaler reset value 0
    cur_req = "R7"; ab_enable = 1; mode = 2'd0; in_b = 1;
    settle(4);
    push(1);
    @(negedge clk); in_a = 1;
    settle(2);
    chk(cnt_en == 0, "R7", "cnt_en before third edge", cnt_en, 0);
    settle(1);
    chk(cnt_en == 1, "R7", "cnt_en on third edge", cnt_en, 1);
    step(0, 1);
    drained("R7");

    // R2 pulse/direction
    cur_req = "R2";
    for (int k = 0; k < 3; k++) begin push(1); step(1, 1); step(0, 1); end
    step(0, 0);
    for (int k = 0; k < 2; k++) begin push(0); step(1, 0); step(0, 0); end
    step(0, 1); step(0, 0);
    drained("R2");

    // R3 quadrature x1
    cur_req = "R3"; mode = 2'd1;
    push(1); step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    step(0, 1); step(1, 1); step(1, 0); push(0); step(0, 0);
    drained("R3");

    // R4 quadrature x2
    cur_req = "R4"; mode = 2'd2;
    push(1); step(1, 0); step(1, 1); push(1); step(0, 1); step(0, 0);
    drained("R4");

    // R5 quadrature x4
    cur_req = "R5"; mode = 2'd3;
    push(1); step(1, 0); push(1); step(1, 1); push(1); step(0, 1); push(1); step(0, 0);
    push(0); step(0, 1); push(0); step(1, 1); push(0); step(1, 0); push(0); step(0, 0);
    drained("R5");

    // R6 disabled inputs
    cur_req = "R6"; ab_enable = 0; e0 = ev_cnt;
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    chk(ev_cnt == e0, "R6", "counts while disabled", ev_cnt - e0, 0);

    // R10 simultaneous change
    cur_req = "R10"; ab_enable = 1; e0 = ev_cnt;
    step(1, 1);
    chk(ev_cnt == e0, "R10", "count on illegal step", ev_cnt - e0, 0);
    chk(noise_err == 1, "R10", "noise after illegal step", noise_err, 1);
    settle(4);
    chk(noise_err == 1, "R9", "noise stays set", noise_err, 1);
    clear_noise(); settle(1);
    chk(noise_err == 0, "R9", "noise cleared", noise_err, 0);
    ab_enable = 0; step(0, 0); ab_enable = 1;
    chk(noise_err == 0, "R6", "no noise while disabled", noise_err, 0);

    // R7/R9 one-cycle glitch
    cur_req = "R7"; mode = 2'd0; e0 = ev_cnt;
    @(negedge clk); in_a = 1;
    @(negedge clk); in_a = 0;
    settle(6);
    chk(ev_cnt == e0, "R7", "count from glitch", ev_cnt - e0, 0);
    chk(noise_err == 1, "R9", "noise from glitch", noise_err, 1);
    clear_noise();

    // R8 prescaler
    cur_req = "R8"; in_b = 1; settle(4);
    push(1);
    @(negedge clk); in_a = 1; settle(3); in_a = 0; settle(6);
    drained("R8");
    @(negedge clk); psc_value = 8'd3; psc_load = 1;
    @(negedge clk); psc_load = 0;
    e0 = ev_cnt;
    @(negedge clk); in_a = 1; settle(3); in_a = 0; settle(16);
    chk(ev_cnt == e0, "R8", "short pulse at prescale 3", ev_cnt - e0, 0);
    clear_noise();
    push(1);
    @(negedge clk); in_a = 1; settle(12); in_a = 0; settle(16);
    drained("R8");
    @(negedge clk); psc_value = 8'd0; psc_load = 1;
    @(negedge clk); psc_load = 0;
    clear_noise();

    // R11 / R12 index
    cur_req = "R11"; ab_enable = 0; in_b = 0; settle(6);
    set_idx(1, 1, "R11"); set_idx(0, 0, "R11");
    cur_req = "R12"; mode = 2'd3; idx_sync = 1;
    set_idx(1, 0, "R12"); set_idx(0, 0, "R12");
    step(1, 0); step(1, 1);
    set_idx(1, 1, "R12"); set_idx(0, 0, "R12");
    step(1, 0); step(0, 0);
    mode = 2'd0;
    set_idx(1, 1, "R12"); set_idx(0, 0, "R12");
    cur_req = "R11"; idx_sync = 0;
    set_idx(1, 1, "R11");
    @(negedge clk); idx_pol = 0; settle(6);
    set_idx(0, 1, "R11");
    set_idx(1, 0, "R11");

    drained("R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule